// File: doc/BRIEF.md
# Bit-Serial Xorshift Word Generator

This block emits a deterministic sequence of pseudo-random words over a valid/ready stream. It keeps a 32-bit xorshift state. While it is generating, it advances that state by one full update per clock. After each update it takes bit 0 of the new state and shifts it into the word being built. Bits arrive least-significant first, so the first update of a word supplies bit 0 and the last supplies bit 31. One word therefore costs 32 updates and 32 cycles.

A job starts with a one-cycle start pulse. The pulse loads a seed and a region size in bytes. The block produces one word for each four bytes of the region. The state is not re-seeded between words: each word continues from where the previous one stopped. When the final word has been taken by the consumer, the block raises a done flag. That flag stays up until the next start. A start that arrives while a job is in progress is ignored.

Top module: `xorshift_word_gen`

## Requirements
- R1: One state update is three sub-steps applied in this order, each truncated to 32 bits: XOR the state with itself shifted left 13, then XOR the result with itself shifted right 17, then XOR that with itself shifted left 5.
- R2: For update number i of a word (i from 0 to 31), bit i of outWord equals bit 0 of the state produced by that update.
- R3: The state after the last update of a word is the starting state of the next word in the same job.
- R4: A seed value of 0 is replaced by 1. A job seeded with 0 yields exactly the words of a job seeded with 1.
- R5: A job produces regionBytes / 4 words, rounded down, so the two low bits of regionBytes are ignored. A count of zero words raises done on the cycle after the start edge and produces no word.
- R6: outValid rises on the 32nd rising edge after the edge that accepts start. For every later word, it rises on the 32nd rising edge after the edge that completes the previous handshake.
- R7: While outValid is high and outReady is low, outValid stays high and outWord stays unchanged.
- R8: done rises on the edge that completes the handshake of the final word. It stays high until the next accepted start. done and busy are never high together.
- R9: busy is high from the accepted start until the final handshake. A start pulse while busy is high changes neither the seed nor the word sequence nor the count.
- R10: After reset, outValid, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Starts a job when the block is not busy |
| seedIn | input | 32 | Starting state, sampled on an accepted start |
| regionBytes | input | 18 | Region size in bytes, sampled on an accepted start |
| outValid | output | 1 | A finished word is available |
| outReady | input | 1 | Consumer accepts the word when high together with outValid |
| outWord | output | 32 | The assembled word |
| busy | output | 1 | A job is in progress |
| done | output | 1 | The last word of the job has been accepted |

## Verification
If the internal state takes one wrong step, the next word at the port shows wrong bits. Because the state carries over, every word after it is also wrong, and the error appears at the next outValid, at most 32 cycles later. An off-by-one in the bit counter moves outValid by a clock, and the bench catches it on that exact cycle. An error in the word counter makes done rise early or late relative to the final handshake. The bench's reference model is compared against outValid, busy, done and outWord on every clock, so each of these faults shows up on the first cycle where it affects a port.

// File: rtl/xsgen_pkg.sv
package xsgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_GEN,
    PH_OUT,
    PH_FIN
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // take the (sanitised) seed, clear the word being built
    logic step;   // one xorshift update plus one collected bit
  } dpStrobe_t;

endpackage

// File: rtl/xsgen_datapath.sv
module xsgen_datapath
  import xsgen_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SH_A = 13,
  parameter int SH_B = 17,
  parameter int SH_C = 5,
  parameter logic [WORD_W-1:0] FALLBACK_SEED = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] seedIn,
  output logic [WORD_W-1:0] wordOut
);

  logic [WORD_W-1:0] xsState;
  logic [WORD_W-1:0] stageA, stageB, nextState;
  logic [WORD_W-1:0] seedSafe;
  logic [WORD_W-1:0] wordAcc;

  // three-stage xorshift, order matters
  always_comb begin
    stageA    = xsState ^ (xsState << SH_A);
    stageB    = stageA ^ (stageA >> SH_B);
    nextState = stageB ^ (stageB << SH_C);
  end

  // a zero state would never leave zero
  assign seedSafe = (seedIn == '0) ? FALLBACK_SEED : seedIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xsState <= FALLBACK_SEED;
      wordAcc <= '0;
    end else if (strobe.load) begin
      xsState <= seedSafe;
      wordAcc <= '0;
    end else if (strobe.step) begin
      xsState <= nextState;
      // new bit enters at the top; after WORD_W steps the first bit sits at bit 0
      wordAcc <= {nextState[0], wordAcc[WORD_W-1:1]};
    end
  end

  assign wordOut = wordAcc;

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    xsState != '0);  // R4

  AST_IDLE_STATE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(xsState));  // R3

endmodule

// File: rtl/xsgen_ctrl.sv
module xsgen_ctrl
  import xsgen_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTES_W = 18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [BYTES_W-1:0] wordsReq,
  input  logic               outReady,
  output dpStrobe_t          strobe,
  output logic               outValid,
  output logic               busy,
  output logic               done
);

  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [BYTES_W-1:0] ONE_WORD = BYTES_W'(1);

  phase_e             phase;
  logic [BIT_W-1:0]   bitCnt;
  logic [BYTES_W-1:0] wordsTotal;
  logic [BYTES_W-1:0] wordsDone;

  logic acceptStart, lastBit, lastWord, handshake;

  assign acceptStart = startPulse && (phase == PH_IDLE || phase == PH_FIN);
  assign lastBit     = (bitCnt == LAST_BIT);
  assign lastWord    = (wordsDone == wordsTotal - ONE_WORD);
  assign handshake   = (phase == PH_OUT) && outReady;

  always_comb begin
    strobe.load = acceptStart;
    strobe.step = (phase == PH_GEN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      bitCnt     <= '0;
      wordsTotal <= '0;
      wordsDone  <= '0;
    end else begin
      case (phase)
        PH_IDLE, PH_FIN: begin
          if (acceptStart) begin
            wordsTotal <= wordsReq;
            wordsDone  <= '0;
            bitCnt     <= '0;
            phase      <= (wordsReq == '0) ? PH_FIN : PH_GEN;
          end
        end
        PH_GEN: begin
          if (lastBit) begin
            bitCnt <= '0;
            phase  <= PH_OUT;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_OUT: begin
          if (handshake) begin
            wordsDone <= wordsDone + ONE_WORD;
            phase     <= lastWord ? PH_FIN : PH_GEN;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign outValid = (phase == PH_OUT);
  assign busy     = (phase == PH_GEN) || (phase == PH_OUT);
  assign done     = (phase == PH_FIN);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));  // R8

  AST_WORDS_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    wordsDone <= wordsTotal);  // R5

  AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_GEN && !lastBit) |=> (phase == PH_GEN && bitCnt == $past(bitCnt) + 1'b1));  // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !(outValid && outReady)) |=> busy);  // R9

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(outValid && outReady) || $past(startPulse)));  // R8

endmodule

// File: rtl/xorshift_word_gen.sv
module xorshift_word_gen
  import xsgen_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTES_W = 18,
  parameter logic [WORD_W-1:0] DEFAULT_SEED = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [WORD_W-1:0]  seedIn,
  input  logic [BYTES_W-1:0] regionBytes,
  output logic               outValid,
  input  logic               outReady,
  output logic [WORD_W-1:0]  outWord,
  output logic               busy,
  output logic               done
);

  localparam int BYTES_PER_WORD_LOG2 = $clog2(WORD_W / 8);

  dpStrobe_t          strobe;
  logic [BYTES_W-1:0] wordsReq;

  assign wordsReq = regionBytes >> BYTES_PER_WORD_LOG2;

  xsgen_ctrl #(
    .WORD_W (WORD_W),
    .BYTES_W(BYTES_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .wordsReq  (wordsReq),
    .outReady  (outReady),
    .strobe    (strobe),
    .outValid  (outValid),
    .busy      (busy),
    .done      (done)
  );

  xsgen_datapath #(
    .WORD_W       (WORD_W),
    .FALLBACK_SEED(DEFAULT_SEED)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .seedIn (seedIn),
    .wordOut(outWord)
  );

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));  // R7

endmodule

// File: tb/xorshift_word_gen_tb.sv
module xorshift_word_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] seedIn = '0;
  logic [17:0] regionBytes = '0;
  logic        outReady = 1'b0;
  logic        outValid, busy, done;
  logic [31:0] outWord;

  int testCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  int readyMode = 0;

  always #5 clk = ~clk;

  xorshift_word_gen dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .seedIn(seedIn),
    .regionBytes(regionBytes), .outValid(outValid), .outReady(outReady),
    .outWord(outWord), .busy(busy), .done(done)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [31:0] refUpdate(logic [31:0] s);  // R1
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [31:0] refWord(inout logic [31:0] s);  // R2, R3
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 32; i++) begin
      s = refUpdate(s);
      w[i] = s[0];
    end
    return w;
  endfunction

  logic [31:0] expQ[$];
  logic [31:0] capQ[$];
  bit mValid = 0, mBusy = 0, mDone = 0;
  int mCount = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      mValid = 0; mBusy = 0; mDone = 0; mCount = 0;
      expQ.delete();
    end else if (mValid) begin
      if (outReady) begin
        capQ.push_back(outWord);
        void'(expQ.pop_front());
        mValid = 0;
        if (expQ.size() == 0) begin mBusy = 0; mDone = 1; end
        else mCount = 32;
      end
    end else if (mBusy) begin
      mCount--;
      if (mCount == 0) mValid = 1;
    end else if (startPulse) begin
      logic [31:0] s;
      s = (seedIn == 0) ? 32'd1 : seedIn;  // R4
      expQ.delete();
      for (int n = 0; n < int'(regionBytes / 4); n++) expQ.push_back(refWord(s));  // R5
      mDone = 0;
      if (expQ.size() == 0) mDone = 1;
      else begin mBusy = 1; mCount = 32; end
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  bit compareOn = 0;
  always @(negedge clk) begin
    if (compareOn && rstN) begin
      check(outValid == mValid, "R6", "outValid", 32'(outValid), 32'(mValid));
      check(busy == mBusy, "R9", "busy", 32'(busy), 32'(mBusy));
      check(done == mDone, "R8", "done", 32'(done), 32'(mDone));
      if (mValid && outValid && expQ.size() > 0)
        check(outWord == expQ[0], "R2", "outWord", outWord, expQ[0]);
    end
  end

  // consumer
  always @(negedge clk) begin
    if (readyMode == 0) outReady <= 1'b1;
    else outReady <= (cyc % 3) != 0;  // backpressure pattern, R7
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic runJob(logic [31:0] seed, logic [17:0] bytes, int mode, int midStartAt);
    capQ.delete();
    readyMode = mode;
    @(negedge clk);
    seedIn = seed; regionBytes = bytes; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int k = 0; !done; k++) begin
      @(negedge clk);
      if (k == midStartAt) begin
        seedIn = 32'hDEAD_0001; regionBytes = 18'd400; startPulse = 1'b1;  // R9
      end else begin
        startPulse = 1'b0;
      end
    end
    startPulse = 1'b0;
  endtask

  logic [31:0] s1Words[$];

  initial begin
    logic [31:0] s;
    logic [31:0] w0, w1;
    repeat (3) @(negedge clk);
    check(outValid == 0 && busy == 0 && done == 0, "R10", "reset outputs",
          {29'd0, outValid, busy, done}, 32'd0);
    rstN = 1'b1;
    compareOn = 1;
    @(negedge clk);
    check(outValid == 0 && busy == 0 && done == 0, "R10", "after release",
          {29'd0, outValid, busy, done}, 32'd0);

    // seed 1, four words, consumer always ready
    runJob(32'd1, 18'd16, 0, -1);
    check(capQ.size() == 4, "R5", "word count 16 bytes", capQ.size(), 32'd4);
    s = 32'd1;
    w0 = refWord(s);
    w1 = refWord(s);
    check(capQ[0] == w0, "R1", "first word seed 1", capQ[0], w0);
    check(capQ[1] == w1, "R3", "second word continues state", capQ[1], w1);
    check(capQ[1] != capQ[0], "R3", "words differ", capQ[1], w0);
    s1Words = capQ;

    // done persists while idle
    repeat (5) @(negedge clk);
    check(done == 1 && busy == 0, "R8", "done held", {30'd0, done, busy}, 32'd2);

    // seed 0 must equal seed 1
    runJob(32'd0, 18'd12, 0, -1);
    check(capQ.size() == 3, "R5", "word count 12 bytes", capQ.size(), 32'd3);
    for (int i = 0; i < 3 && i < capQ.size(); i++)
      check(capQ[i] == s1Words[i], "R4", "zero seed word", capQ[i], s1Words[i]);

    // backpressure
    runJob(32'h1234_5678, 18'd12, 1, -1);
    check(capQ.size() == 3, "R7", "words under backpressure", capQ.size(), 32'd3);
    readyMode = 0;

    // start while busy is ignored
    runJob(32'hCAFE_F00D, 18'd8, 0, 10);
    s = 32'hCAFE_F00D;
    w0 = refWord(s);
    check(capQ.size() == 2, "R9", "count unaffected by mid start", capQ.size(), 32'd2);
    check(capQ.size() > 0 && capQ[0] == w0, "R9", "seed unaffected", capQ[0], w0);

    // low byte bits ignored
    runJob(32'd7, 18'd7, 0, -1);
    check(capQ.size() == 1, "R5", "7 bytes gives one word", capQ.size(), 32'd1);

    // zero words
    @(negedge clk);
    regionBytes = 18'd3; seedIn = 32'd9; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(done == 1 && outValid == 0 && busy == 0, "R5", "zero-word job",
          {29'd0, done, outValid, busy}, 32'd4);
    repeat (40) @(negedge clk);
    check(outValid == 0, "R5", "no word for empty job", 32'(outValid), 32'd0);

    compareOn = 0;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule